// File: doc/BRIEF.md
# Guarded Power-of-Two Clock Divider

This block takes a fast reference clock and produces a one-cycle-wide system clock enable that fires once every 2^k reference cycles. k is the active division code, from 0 (divide by 1) to 8 (divide by 256). A free-running counter on the reference clock sets the pulse grid. The counter state cannot be seen from outside the block.

A one-byte register write port, qualified by the system enable, changes the code. Two writes are needed. The first is an unlock write carrying only the change-enable flag. The second carries the new code, and it counts only if it lands within a short window of system ticks after the unlock.

An accepted code is held as pending. It is applied only on a pulse where the old grid and the new grid coincide. This way the enable never shows a gap shorter than either the old or the new period. Software reads the active code on a dedicated output.

Top module: `clkdiv_guard`

## Requirements
- R1: While reset is asserted and right after it is released, `div_sel_o` is 0 and `sys_en_o` is high on every reference cycle.
- R2: With active code k, `sys_en_o` is a single-cycle pulse, and successive pulses are exactly 2^k reference cycles apart.
- R3: The write port is sampled only on reference cycles where `sys_en_o` is high. A write presented while `sys_en_o` is low has no effect. Byte layout: bit 7 is the change-enable flag and bits 3:0 are the division code.
- R4: Only the exact value 0x80 opens the unlock window. Any other value, such as 0x81, does not open it. A code write made without an open window leaves the setting unchanged.
- R5: After an unlock, a write with bit 7 clear and a code of at most 8 is accepted if it arrives on one of the next four system ticks. A later write is ignored, and the window closes by itself.
- R6: Codes 9 to 15 are reserved. Writing one leaves the setting unchanged and closes the window.
- R7: A write with bit 7 set other than 0x80 cancels an open window. A new 0x80 write during the window restarts a full four-tick window.
- R8: `div_sel_o` never exceeds 8.
- R9: An accepted code takes effect on the first pulse of the old grid where the low max(old,new) counter bits are all ones. Across a change, the pulse gaps are old periods followed by new periods, and none is shorter.
- R10: `div_sel_o` changes only in the reference cycle that directly follows a pulse of `sys_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, sampled on system ticks |
| wr_data_i | input | 8 | Register write byte (bit 7 change-enable, bits 3:0 code) |
| sys_en_o | output | 1 | Divided system clock enable pulse |
| div_sel_o | output | 4 | Active division code |

## Verification
The bound checker watches four properties on every reference cycle: the pulse spacing always equals 2^code for the code currently shown, the code stays in range, the code moves only right after a pulse, and code 0 gives a pulse every cycle. Between them they cover the no-shortened-period property across every change.

The unlock protocol depends on sequences of writes over several ticks, so only the bench scenarios can show it. These cover window expiry, cancel and restart, reserved codes, writes off the tick, and the order of the old and new gaps around a switch.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
    localparam int SEL_W   = 4;
    localparam int REG_W   = 8;
    localparam int ARM_BIT = 7;
    localparam logic [REG_W-1:0] ARM_VAL = REG_W'(1) << ARM_BIT;
endpackage

// File: rtl/prescale_unlock.sv
module prescale_unlock
    import prescale_pkg::*;
#(
    parameter int MAX_CODE  = 8,
    parameter int WIN_TICKS = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic             upd_vld_o,
    output logic [SEL_W-1:0] upd_code_o
);
    localparam int WIN_W = $clog2(WIN_TICKS + 1);

    typedef struct packed {
        logic [WIN_W-1:0] win;
    } unl_st_t;

    unl_st_t st_d, st_q;
    logic    is_arm;
    logic    code_ok;

    always_comb begin
        st_d       = st_q;
        upd_vld_o  = 1'b0;
        upd_code_o = wr_data_i[SEL_W-1:0];
        is_arm     = (wr_data_i == ARM_VAL);
        code_ok    = (wr_data_i[SEL_W-1:0] <= SEL_W'(MAX_CODE));
        if (tick_i) begin
            if (wr_en_i) begin
                if (is_arm) begin
                    st_d.win = WIN_W'(WIN_TICKS);
                end else begin
                    st_d.win = '0;
                    if ((st_q.win != '0) && !wr_data_i[ARM_BIT] && code_ok) begin
                        upd_vld_o = 1'b1;
                    end
                end
            end else if (st_q.win != '0) begin
                st_d.win = st_q.win - WIN_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/prescale_divider.sv
module prescale_divider
    import prescale_pkg::*;
#(
    parameter int MAX_CODE = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             upd_vld_i,
    input  logic [SEL_W-1:0] upd_code_i,
    output logic             tick_o,
    output logic [SEL_W-1:0] code_o
);
    localparam int CNT_W = MAX_CODE;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] code;
        logic [SEL_W-1:0] pend;
        logic             pend_vld;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [SEL_W-1:0] span;

    // True when the low k counter bits are all ones.
    function automatic logic on_grid(input logic [CNT_W-1:0] c, input logic [SEL_W-1:0] k);
        logic hit;
        hit = 1'b1;
        for (int i = 0; i < CNT_W; i++) begin
            if ((i < int'(k)) && !c[i]) hit = 1'b0;
        end
        return hit;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
        tick_o   = on_grid(st_q.cnt, st_q.code);
        span     = (st_q.pend > st_q.code) ? st_q.pend : st_q.code;
        if (st_q.pend_vld && on_grid(st_q.cnt, span)) begin
            st_d.code     = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        if (upd_vld_i) begin
            st_d.pend     = upd_code_i;
            st_d.pend_vld = 1'b1;
        end
        code_o = st_q.code;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/clkdiv_guard.sv
module clkdiv_guard
    import prescale_pkg::*;
#(
    parameter int MAX_CODE  = 8,
    parameter int WIN_TICKS = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic             sys_en_o,
    output logic [SEL_W-1:0] div_sel_o
);
    logic             tick;
    logic             upd_vld;
    logic [SEL_W-1:0] upd_code;

    prescale_unlock #(
        .MAX_CODE (MAX_CODE),
        .WIN_TICKS(WIN_TICKS)
    ) u_unlock (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .upd_vld_o (upd_vld),
        .upd_code_o(upd_code)
    );

    prescale_divider #(
        .MAX_CODE(MAX_CODE)
    ) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .upd_vld_i (upd_vld),
        .upd_code_i(upd_code),
        .tick_o    (tick),
        .code_o    (div_sel_o)
    );

    assign sys_en_o = tick;
endmodule

// File: rtl/prescale_chk.sv
module prescale_chk
    import prescale_pkg::*;
#(
    parameter int MAX_CODE = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sys_en_i,
    input logic [SEL_W-1:0] div_sel_i
);
    localparam int CNT_W = MAX_CODE;

    logic [CNT_W:0] cyc_q;
    logic           seen_q;
    logic [CNT_W:0] want_gap;

    assign want_gap = (CNT_W+1)'(1) << div_sel_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cyc_q  <= '0;
            seen_q <= 1'b0;
        end else if (sys_en_i) begin
            cyc_q  <= (CNT_W+1)'(1);
            seen_q <= 1'b1;
        end else if (cyc_q != '1) begin
            cyc_q <= cyc_q + (CNT_W+1)'(1);
        end
    end

    // R8
    sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_sel_i <= SEL_W'(MAX_CODE));

    // R10
    sel_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(div_sel_i) |-> $past(sys_en_i));

    // R9
    pulse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sys_en_i && seen_q) |-> (cyc_q == want_gap));

    // R2
    full_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_sel_i == '0) |-> sys_en_i);
endmodule

bind clkdiv_guard prescale_chk #(.MAX_CODE(MAX_CODE)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sys_en_i (sys_en_o),
    .div_sel_i(div_sel_o)
);

// File: tb/tb_clkdiv_guard.sv
module tb_clkdiv_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sys_en;
    logic [3:0] div_sel;

    int n_tests = 0;
    int n_fail = 0;
    int mon_tests = 0;
    int mon_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clkdiv_guard dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .sys_en_o (sys_en),
        .div_sel_o(div_sel)
    );

    typedef struct packed {
        logic [3:0] idle;
        logic [7:0] data;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 8'h03}, '{4'd3, 8'h01}, '{4'd4, 8'h05},
        '{4'd2, 8'h09}, '{4'd1, 8'h88}, '{4'd0, 8'h08},
        '{4'd0, 8'h00}, '{4'd3, 8'h02}, '{4'd2, 8'h0F}
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Caller sits on a falling edge.
    task automatic sys_write(input logic [7:0] d);
        while (!sys_en) @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic tick_idle();
        while (!sys_en) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic measure_gap(output int g);
        while (!sys_en) @(negedge clk);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!sys_en);
    endtask

    task automatic settle();
        repeat (600) @(negedge clk);
    endtask

    task automatic check_trans(input int oldc, input int newc, input string req);
        int  g;
        bit  ok;
        bit  seen_new;
        ok = 1'b1;
        seen_new = 1'b0;
        sys_write(8'h80);
        sys_write(8'(newc));
        for (int i = 0; i < 24; i++) begin
            measure_gap(g);
            if (g == (1 << newc)) seen_new = 1'b1;
            else if (!(g == (1 << oldc) && !seen_new)) ok = 1'b0;
        end
        check({req, " gap order"}, int'(ok && seen_new), 1);
        settle();
        check({req, " final code"}, int'(div_sel), newc);
    endtask

    // R10: code moves only after a pulse
    logic       prev_en = 1'b0;
    logic [3:0] prev_sel = 4'd0;
    always @(negedge clk) begin
        if (rst_n && (div_sel != prev_sel)) begin
            mon_tests++;
            if (!prev_en) begin
                mon_fail++;
                $display("FAIL R10: code moved without pulse, got %0d expected 1", prev_en);
            end
        end
        prev_en  <= sys_en;
        prev_sel <= div_sel;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed",
                     n_tests + mon_tests + 1, n_fail + mon_fail + 1);
            $finish;
        end
    end

    initial begin
        int cur;
        int g;
        int ones;
        logic [7:0] d;
        bit acc;

        repeat (3) @(negedge clk);
        check("R1 sel in reset", int'(div_sel), 0);
        rst_n = 1'b1;
        ones = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ones += int'(sys_en);
        end
        check("R1 full-rate enable", ones, 6);
        check("R1 sel after reset", int'(div_sel), 0);

        // Vector table: unlock, idle ticks, then code write
        cur = 0;
        for (int v = 0; v < NVEC; v++) begin
            d = VECS[v].data;
            acc = (VECS[v].idle <= 4'd3) && !d[7] && (d[3:0] <= 4'd8);
            sys_write(8'h80);
            for (int k = 0; k < int'(VECS[v].idle); k++) tick_idle();
            sys_write(d);
            settle();
            if (acc) cur = int'(d[3:0]);
            if (VECS[v].idle > 4'd3) check("R5 late write ignored", int'(div_sel), cur);
            else if (d[7]) check("R7 cancel by flagged write", int'(div_sel), cur);
            else if (d[3:0] > 4'd8) check("R6 reserved code ignored", int'(div_sel), cur);
            else check("R5 code accepted in window", int'(div_sel), cur);
            measure_gap(g);
            measure_gap(g);
            check("R2 pulse spacing", g, 1 << cur);
        end

        // R4: code write with no unlock
        sys_write(8'h04);
        settle();
        check("R4 no unlock ignored", int'(div_sel), cur);

        // R4: near-miss unlock value
        sys_write(8'h81);
        sys_write(8'h04);
        settle();
        check("R4 0x81 does not unlock", int'(div_sel), cur);

        // R7: restart of window by second unlock
        sys_write(8'h80);
        tick_idle();
        tick_idle();
        sys_write(8'h80);
        tick_idle();
        tick_idle();
        tick_idle();
        sys_write(8'h03);
        settle();
        cur = 3;
        check("R7 re-unlock restarts window", int'(div_sel), cur);

        // R3: unlock presented off the tick is not sampled
        while (sys_en) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h80;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
        sys_write(8'h01);
        settle();
        check("R3 write off tick ignored", int'(div_sel), cur);

        // R9: transitions both ways
        sys_write(8'h80);
        sys_write(8'h05);
        settle();
        check("R9 setup code", int'(div_sel), 5);
        check_trans(5, 1, "R9 slow-to-fast");
        check_trans(1, 5, "R9 fast-to-slow");
        check_trans(5, 0, "R9 to full rate");
        check("R8 code in range", int'(div_sel <= 4'd8), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests + mon_tests, n_fail + mon_fail);
        $finish;
    end
endmodule